// File: doc/BRIEF.md
# DRAM Refresh and Initialization Sequencer

This block brings up an asynchronous DRAM with 1024 rows and keeps it refreshed. After reset it keeps every strobe inactive for a power-up pause. It then runs a warm-up burst of CAS-before-RAS cycles. After that it owes one refresh per fixed interval, so that all rows are covered within the retention period. Each refresh is a CAS-before-RAS cycle. The row comes from the device's own counter, so the block drives no address, and write enable, output enable and the data pins play no part.

A memory-access controller shares the strobes with it through a request/grant handshake. The strobe outputs are active low and sit high whenever the block is not refreshing, so the system can AND them with the access controller's own strobes. A quiesce input stops all activity for low-power periods. If that stop lasts longer than the device's idle limit, the warm-up burst runs again before any grant. All times are given in nanoseconds and rounded up to whole clock cycles.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is high and on the cycle after it, `ras_n`, `ucas_n` and `lcas_n` are 1 and `init_done`, `acc_gnt` and `ref_busy` are 0.
- R2: After reset is released, both CAS strobes stay high for at least PAUSE_C = ceil(PAUSE_NS/CLK_NS) cycles.
- R3: After the pause, exactly INIT_CYCLES CAS-before-RAS cycles run before `init_done` goes to 1. `acc_gnt` stays 0 whenever `init_done` is 0.
- R4: In every refresh cycle both CAS strobes are low for at least ceil(TCSR_NS/CLK_NS) cycles before `ras_n` falls. They stay low for at least ceil(TCHR_NS/CLK_NS) cycles after it falls.
- R5: `ras_n` stays low for exactly ceil(TRAS_NS/CLK_NS) cycles in a refresh. Between two RAS pulses it stays high for at least max(ceil(TRP_NS/CLK_NS), ceil(TRC_NS/CLK_NS) minus the low time) cycles.
- R6: Once `init_done` is 1, one refresh is owed every ceil(REF_INT_NS/CLK_NS) cycles. At most DEBT_MAX owed refreshes are kept; further ticks are dropped.
- R7: While a refresh is owed, a request is not granted until the owed refreshes are done. No strobe activity happens while `acc_gnt` is 1.
- R8: With nothing owed, `acc_gnt` rises within two cycles of `acc_req` and holds until `acc_req` drops. It falls on the next clock edge.
- R9: While `quiesce` is 1 and the current refresh has finished, no RAS pulse is issued and `acc_gnt` stays 0.
- R10: When `quiesce` drops after being held more than ceil(IDLE_NS/CLK_NS) cycles, `init_done` falls and exactly INIT_CYCLES CAS-before-RAS cycles run again. After a shorter hold, `init_done` stays 1.
- R11: `ref_busy` is 1 whenever the block drives any strobe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| acc_req | input | 1 | Access controller asks for the DRAM |
| quiesce | input | 1 | Stop all activity (low-power hold) |
| acc_gnt | output | 1 | Access controller owns the strobes |
| init_done | output | 1 | Power-up / re-initialization warm-up complete |
| ref_busy | output | 1 | A refresh cycle, including its precharge, is in progress |
| ras_n | output | 1 | Row strobe, active low |
| ucas_n | output | 1 | Upper-byte column strobe, active low |
| lcas_n | output | 1 | Lower-byte column strobe, active low |

## Verification
The bench builds the block with a 5 ns clock, a 1000 ns pause (200 cycles), a 2000 ns refresh interval (400 cycles) and a 4000 ns idle limit (800 cycles). The strobe timings keep their slow-grade nanosecond values. With these settings the pause, several refresh intervals, debt saturation behind a long grant, and quiesce holds on both sides of the idle limit fit into a short run. The 2/12/9-cycle setup, strobe and precharge counts and the 8-cycle warm-up are checked at full size.

// File: rtl/dref_pkg.sv
package dref_pkg;

  typedef enum logic [2:0] {
    S_PAUSE, S_BURST, S_READY, S_GRANT, S_REFRESH, S_HOLD
  } seq_state_t;

  typedef enum logic [1:0] {
    E_IDLE, E_SETUP, E_STROBE, E_PRECH
  } cbr_phase_t;

  // Round a nanosecond time up to whole clock cycles, never below one.
  function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                               input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

endpackage

// File: rtl/dref_interval.sv
module dref_interval #(
  parameter int unsigned INT_C    = 3125,
  parameter int unsigned DEBT_MAX = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic take,
  output logic pending
);
  localparam int unsigned IW = $clog2(INT_C + 1);
  localparam int unsigned DW = $clog2(DEBT_MAX + 1);

  logic [IW-1:0] cnt;
  logic [DW-1:0] debt;
  logic          tick;

  always_comb tick = (cnt == IW'(INT_C - 1));

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      debt <= '0;
    end else begin
      cnt <= tick ? '0 : cnt + 1'b1;
      case ({tick, take})
        2'b10:   if (debt != DW'(DEBT_MAX)) debt <= debt + 1'b1;
        2'b01:   if (debt != '0) debt <= debt - 1'b1;
        default: ;
      endcase
    end
  end

  assign pending = (debt != '0);

endmodule

// File: rtl/dref_cbr_engine.sv
module dref_cbr_engine
  import dref_pkg::*;
#(
  parameter int unsigned SETUP_C  = 2,
  parameter int unsigned STROBE_C = 12,
  parameter int unsigned HOLD_C   = 2,
  parameter int unsigned PRECH_C  = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done,
  output logic ras_n,
  output logic cas_n
);
  localparam int unsigned M1   = (SETUP_C > STROBE_C) ? SETUP_C : STROBE_C;
  localparam int unsigned MAXC = (M1 > PRECH_C) ? M1 : PRECH_C;
  localparam int unsigned CW   = $clog2(MAXC + 1);

  cbr_phase_t    phase;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= E_IDLE;
      cnt   <= '0;
      ras_n <= 1'b1;
      cas_n <= 1'b1;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        E_IDLE: if (start) begin
          phase <= E_SETUP;
          cnt   <= '0;
          cas_n <= 1'b0;
        end
        E_SETUP: if (cnt == CW'(SETUP_C - 1)) begin
          phase <= E_STROBE;
          cnt   <= '0;
          ras_n <= 1'b0;
        end else cnt <= cnt + 1'b1;
        E_STROBE: begin
          if (cnt == CW'(HOLD_C - 1)) cas_n <= 1'b1;
          if (cnt == CW'(STROBE_C - 1)) begin
            phase <= E_PRECH;
            cnt   <= '0;
            ras_n <= 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        E_PRECH: if (cnt == CW'(PRECH_C - 1)) begin
          phase <= E_IDLE;
          cnt   <= '0;
          done  <= 1'b1;
        end else cnt <= cnt + 1'b1;
        default: phase <= E_IDLE;
      endcase
    end
  end

  assign busy = (phase != E_IDLE);

endmodule

// File: rtl/dref_ctrl.sv
module dref_ctrl
  import dref_pkg::*;
#(
  parameter int unsigned PAUSE_C = 40000,
  parameter int unsigned INIT_N  = 8,
  parameter int unsigned IDLE_C  = 1600000
) (
  input  logic clk,
  input  logic rst,
  input  logic acc_req,
  input  logic quiesce,
  input  logic pending,
  input  logic eng_done,
  output logic launch,
  output logic take,
  output logic acc_gnt,
  output logic init_done
);
  localparam int unsigned PW = $clog2(PAUSE_C + 1);
  localparam int unsigned BW = $clog2(INIT_N + 1);
  localparam int unsigned IW = $clog2(IDLE_C + 2);

  seq_state_t    state;
  logic [PW-1:0] pause_cnt;
  logic [BW-1:0] burst_cnt;
  logic [IW-1:0] idle_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_PAUSE;
      pause_cnt <= '0;
      burst_cnt <= '0;
      idle_cnt  <= '0;
      launch    <= 1'b0;
      take      <= 1'b0;
      acc_gnt   <= 1'b0;
      init_done <= 1'b0;
    end else begin
      launch <= 1'b0;
      take   <= 1'b0;
      unique case (state)
        S_PAUSE: if (pause_cnt == PW'(PAUSE_C - 1)) begin
          state     <= S_BURST;
          burst_cnt <= '0;
          launch    <= 1'b1;
        end else pause_cnt <= pause_cnt + 1'b1;
        S_BURST: if (eng_done) begin
          if (burst_cnt == BW'(INIT_N - 1)) begin
            state     <= S_READY;
            init_done <= 1'b1;
          end else begin
            burst_cnt <= burst_cnt + 1'b1;
            launch    <= 1'b1;
          end
        end
        S_READY: begin
          if (quiesce) begin
            state    <= S_HOLD;
            idle_cnt <= '0;
          end else if (pending) begin
            state  <= S_REFRESH;
            launch <= 1'b1;
            take   <= 1'b1;
          end else if (acc_req) begin
            state   <= S_GRANT;
            acc_gnt <= 1'b1;
          end
        end
        S_GRANT: if (!acc_req) begin
          state   <= S_READY;
          acc_gnt <= 1'b0;
        end
        S_REFRESH: if (eng_done) state <= S_READY;
        S_HOLD: begin
          if (!quiesce) begin
            if (idle_cnt > IW'(IDLE_C)) begin
              state     <= S_BURST;
              init_done <= 1'b0;
              burst_cnt <= '0;
              launch    <= 1'b1;
            end else state <= S_READY;
          end else if (idle_cnt != IW'(IDLE_C + 1)) begin
            idle_cnt <= idle_cnt + 1'b1;
          end
        end
        default: state <= S_PAUSE;
      endcase
    end
  end

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dref_pkg::*;
#(
  parameter int unsigned CLK_NS      = 5,
  parameter int unsigned PAUSE_NS    = 200000,
  parameter int unsigned REF_INT_NS  = 15625,
  parameter int unsigned IDLE_NS     = 8000000,
  parameter int unsigned TRP_NS      = 40,
  parameter int unsigned TRAS_NS     = 60,
  parameter int unsigned TRC_NS      = 104,
  parameter int unsigned TCSR_NS     = 10,
  parameter int unsigned TCHR_NS     = 10,
  parameter int unsigned INIT_CYCLES = 8,
  parameter int unsigned DEBT_MAX    = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic acc_req,
  input  logic quiesce,
  output logic acc_gnt,
  output logic init_done,
  output logic ref_busy,
  output logic ras_n,
  output logic ucas_n,
  output logic lcas_n
);
  localparam int unsigned PAUSE_C  = ns_to_cycles(PAUSE_NS, CLK_NS);
  localparam int unsigned INT_C    = ns_to_cycles(REF_INT_NS, CLK_NS);
  localparam int unsigned IDLE_C   = ns_to_cycles(IDLE_NS, CLK_NS);
  localparam int unsigned SETUP_C  = ns_to_cycles(TCSR_NS, CLK_NS);
  localparam int unsigned STROBE_C = ns_to_cycles(TRAS_NS, CLK_NS);
  localparam int unsigned HOLD_RAW = ns_to_cycles(TCHR_NS, CLK_NS);
  localparam int unsigned HOLD_C   = (HOLD_RAW > STROBE_C) ? STROBE_C : HOLD_RAW;
  localparam int unsigned TRP_C    = ns_to_cycles(TRP_NS, CLK_NS);
  localparam int unsigned TRC_C    = ns_to_cycles(TRC_NS, CLK_NS);
  localparam int unsigned PRECH_C  = (TRC_C > STROBE_C + TRP_C) ? TRC_C - STROBE_C : TRP_C;

  logic launch, take, pending, eng_done, eng_busy, cas_n;

  dref_ctrl #(
    .PAUSE_C (PAUSE_C),
    .INIT_N  (INIT_CYCLES),
    .IDLE_C  (IDLE_C)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .acc_req   (acc_req),
    .quiesce   (quiesce),
    .pending   (pending),
    .eng_done  (eng_done),
    .launch    (launch),
    .take      (take),
    .acc_gnt   (acc_gnt),
    .init_done (init_done)
  );

  dref_interval #(
    .INT_C    (INT_C),
    .DEBT_MAX (DEBT_MAX)
  ) u_interval (
    .clk     (clk),
    .rst     (rst),
    .en      (init_done),
    .take    (take),
    .pending (pending)
  );

  dref_cbr_engine #(
    .SETUP_C  (SETUP_C),
    .STROBE_C (STROBE_C),
    .HOLD_C   (HOLD_C),
    .PRECH_C  (PRECH_C)
  ) u_engine (
    .clk   (clk),
    .rst   (rst),
    .start (launch),
    .busy  (eng_busy),
    .done  (eng_done),
    .ras_n (ras_n),
    .cas_n (cas_n)
  );

  assign ucas_n   = cas_n;
  assign lcas_n   = cas_n;
  assign ref_busy = eng_busy;

endmodule

// File: rtl/dref_checks.sv
module dref_checks #(
  parameter int unsigned MIN_LOW = 12
) (
  input logic clk,
  input logic rst,
  input logic ras_n,
  input logic ucas_n,
  input logic lcas_n,
  input logic acc_gnt,
  input logic init_done,
  input logic ref_busy
);
  logic [31:0] low_run;

  always_ff @(posedge clk) begin
    if (rst)         low_run <= '0;
    else if (!ras_n) low_run <= low_run + 1'b1;
    else             low_run <= '0;
  end

  assert_cbr_order_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> (!ucas_n && !lcas_n));

  assert_ras_width_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(ras_n) |-> (low_run >= MIN_LOW));

  assert_no_early_grant_R3: assert property (@(posedge clk) disable iff (rst)
    !init_done |-> !acc_gnt);

  assert_grant_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    acc_gnt |-> (ras_n && ucas_n && lcas_n && !ref_busy));

  assert_busy_cover_R11: assert property (@(posedge clk) disable iff (rst)
    (!ras_n || !ucas_n || !lcas_n) |-> ref_busy);

endmodule

bind dram_refresh_seq dref_checks #(.MIN_LOW(STROBE_C)) u_checks (
  .clk       (clk),
  .rst       (rst),
  .ras_n     (ras_n),
  .ucas_n    (ucas_n),
  .lcas_n    (lcas_n),
  .acc_gnt   (acc_gnt),
  .init_done (init_done),
  .ref_busy  (ref_busy)
);

// File: tb/dram_refresh_seq_tb.sv
`timescale 1ns/1ps
module dram_refresh_seq_tb;
  localparam int PAUSE_C = 200;
  localparam int SETUP_C = 2;
  localparam int LOW_C   = 12;
  localparam int HOLD_C  = 2;
  localparam int PRE_C   = 9;

  typedef struct packed { logic [15:0] hold; logic reinit; } hvec_t;
  localparam hvec_t VEC [4] = '{'{16'd300, 1'b0}, '{16'd760, 1'b0},
                                '{16'd870, 1'b1}, '{16'd1500, 1'b1}};

  logic clk = 0, rst, acc_req, quiesce;
  logic acc_gnt, init_done, ref_busy, ras_n, ucas_n, lcas_n;

  always #2.5 clk = ~clk;

  dram_refresh_seq #(
    .CLK_NS(5), .PAUSE_NS(1000), .REF_INT_NS(2000), .IDLE_NS(4000)
  ) u_dut (
    .clk(clk), .rst(rst), .acc_req(acc_req), .quiesce(quiesce),
    .acc_gnt(acc_gnt), .init_done(init_done), .ref_busy(ref_busy),
    .ras_n(ras_n), .ucas_n(ucas_n), .lcas_n(lcas_n)
  );

  int n_chk = 0, n_err = 0, n_falls = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Strobe monitor
  int cas_run = 0, low_run = 0, high_run = 0;
  bit prev_ras = 1, prev_cas = 1, seen_pulse = 0;
  always @(negedge clk) begin
    if (rst) begin
      cas_run = 0; low_run = 0; high_run = 0; prev_ras = 1; prev_cas = 1; seen_pulse = 0;
    end else begin
      if (prev_ras && !ras_n) begin
        n_falls++;
        chk(cas_run >= SETUP_C, "R4", cas_run, SETUP_C);
        if (seen_pulse) chk(high_run >= PRE_C, "R5", high_run, PRE_C);
        seen_pulse = 1;
      end
      if (!prev_ras && ras_n) chk(low_run == LOW_C, "R5", low_run, LOW_C);
      if (!prev_cas && ucas_n && !ras_n) chk(low_run >= HOLD_C, "R4", low_run, HOLD_C);
      if (ucas_n != lcas_n) chk(0, "R4", lcas_n, ucas_n);
      if (acc_gnt && !init_done) chk(0, "R3", acc_gnt, 0);
      if (acc_gnt && (!ras_n || !ucas_n)) chk(0, "R7", ras_n, 1);
      if ((!ras_n || !ucas_n) && !ref_busy) chk(0, "R11", ref_busy, 1);
      cas_run  = ucas_n ? 0 : cas_run + 1;
      low_run  = ras_n ? 0 : low_run + 1;
      high_run = ras_n ? high_run + 1 : 0;
      prev_ras = ras_n;
      prev_cas = ucas_n;
    end
  end

  task automatic wait_idle();
    while (ref_busy || acc_gnt || !init_done) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(0, "watchdog", 0, 1);
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int cyc, base, k;
    rst = 1; acc_req = 0; quiesce = 0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(ras_n && ucas_n && lcas_n, "R1", {ras_n, ucas_n, lcas_n}, 7);
    chk(!init_done && !acc_gnt && !ref_busy, "R1", {init_done, acc_gnt, ref_busy}, 0);
    rst = 0; acc_req = 1;
    cyc = 0;
    while (ucas_n) begin @(negedge clk); cyc++; end
    chk(cyc >= PAUSE_C, "R2", cyc, PAUSE_C);
    while (!init_done) @(negedge clk);
    chk(n_falls == 8, "R3", n_falls, 8);
    k = 0;
    while (!acc_gnt && k < 3) begin @(negedge clk); k++; end
    chk(acc_gnt, "R8", acc_gnt, 1);
    acc_req = 0;
    @(negedge clk);
    chk(!acc_gnt, "R8", acc_gnt, 0);

    // Quiesce table: R9 and R10
    for (int i = 0; i < 4; i++) begin
      wait_idle();
      quiesce = 1; acc_req = 1;
      repeat (30) @(negedge clk);
      base = n_falls;
      repeat (int'(VEC[i].hold) - 30) @(negedge clk);
      chk(n_falls == base, "R9", n_falls - base, 0);
      chk(!acc_gnt, "R9", acc_gnt, 0);
      quiesce = 0; acc_req = 0;
      repeat (3) @(negedge clk);
      chk(init_done == !VEC[i].reinit, "R10", init_done, !VEC[i].reinit);
      if (VEC[i].reinit) begin
        base = n_falls;
        while (!init_done) @(negedge clk);
        chk(n_falls - base == 8, "R10", n_falls - base, 8);
      end
    end

    // R7: no refresh during a grant, owed refreshes go first
    wait_idle();
    acc_req = 1;
    while (!acc_gnt) @(negedge clk);
    base = n_falls;
    repeat (1000) @(negedge clk);
    chk(n_falls == base, "R7", n_falls - base, 0);
    acc_req = 0;
    @(negedge clk);
    acc_req = 1;
    base = n_falls;
    while (!acc_gnt) @(negedge clk);
    chk(n_falls - base >= 2, "R7", n_falls - base, 2);

    // R6: owed refreshes saturate at DEBT_MAX = 4
    repeat (4000) @(negedge clk);
    acc_req = 0;
    base = n_falls;
    repeat (130) @(negedge clk);
    chk((n_falls - base >= 4) && (n_falls - base <= 5), "R6", n_falls - base, 4);

    // R6: steady rate, one refresh per 400 cycles
    wait_idle();
    base = n_falls;
    repeat (4000) @(negedge clk);
    chk((n_falls - base >= 9) && (n_falls - base <= 11), "R6", n_falls - base, 10);

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule